// File: doc/BRIEF.md
# Per-Card Distributed Bus Arbitration Unit

This block sits on each card that can take ownership of a shared backplane bus. A local engine asks for the bus with a level request; the unit joins a distributed contest over seven wired-AND priority lines and reports back with a proceed level once the card owns the bus. The shared lines are modelled as active-low, open-drain style pairs: each line the unit drives has an output (low means "pull the line down") and the resolved bus value comes back on a separate input.

A contest starts only on a quiet bus. The unit then pulls the shared request line and its own priority line down in the same clock. A central grant falling low starts the resolution. At the first clock edge that sees the grant low, the unit records whether it holds the highest requesting level. The winner waits for the current transfer to end (address strobe and acknowledge both high), then takes the acknowledge line and enables the card's bus drivers. Every other contender drops its lines once the acknowledge appears and tries again when the bus is quiet. The owner keeps the bus until its engine withdraws the request and the acknowledge line is high. Every state change happens on the rising clock edge.

Top module: `arb_unit`

## Requirements
- R1: While reset is low, br_n_o, dp_n_o and bgack_n_o are high, and drv_en_o and proceed_o are low.
- R2: When req_i is high and the bus is quiet at a rising edge, br_n_o and dp_n_o both go low at that edge. They always share the same value.
- R3: The bus counts as quiet when br_n_i, bg_n_i and bgack_n_i are all high. While it is not quiet, no new request starts, and br_n_o stays high.
- R4: At the first edge with bg_n_i low while requesting, the unit wins if dp_n_i[MY_LEVEL-1] is low and no bit dp_n_i[k] with k >= MY_LEVEL is low. Bit k carries priority line k+1, and line 7 ranks highest. Lower lines do not block a win.
- R5: A winner pulls bgack_n_o low at the first edge where as_n_i and dtack_n_i are both sampled high. Until then, bgack_n_o stays high.
- R6: A contender that has not taken the bus releases br_n_o and dp_n_o at the first edge where bgack_n_i is sampled low. It asks again once the bus is quiet, provided req_i is still high.
- R7: While it owns the bus, the unit keeps bgack_n_o low regardless of the priority lines or of bg_n_i.
- R8: The owner raises bgack_n_o and clears drv_en_o at the first edge where req_i is low and dtack_n_i is high. A low dtack_n_i delays the release.
- R9: proceed_o and drv_en_o are high exactly when bgack_n_o is low.
- R10: While it owns the bus, the unit keeps br_n_o and dp_n_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Local engine wants or holds the bus |
| proceed_o | output | 1 | Local engine may run bus cycles |
| br_n_i | input | 1 | Resolved shared request line |
| br_n_o | output | 1 | Pull-down on the shared request line |
| bg_n_i | input | 1 | Central grant line |
| bgack_n_i | input | 1 | Resolved grant-acknowledge line |
| bgack_n_o | output | 1 | Pull-down on the grant-acknowledge line |
| as_n_i | input | 1 | Address strobe, low during a transfer |
| dtack_n_i | input | 1 | Transfer acknowledge, low while a slave responds |
| dp_n_i | input | NUM_LINES | Resolved priority lines; bit k is line k+1 |
| dp_n_o | output | 1 | Pull-down on this card's own priority line |
| drv_en_o | output | 1 | Enable for the card's tri-state bus drivers |

## Verification
The contest is tried with four input patterns. In the first, the unit asks alone, which shows that a quiet bus leads to a win and then ownership. In the second, a higher line is pulled at the grant edge, which separates losing from winning and checks the drop of both lines on a foreign acknowledge. In the third, a lower line is pulled at the same moment, which shows that lower levels do not block a win. In the fourth, busy request, grant or acknowledge lines hold back a new start, which separates arrival-order service from plain priority. While the unit owns the bus, a higher priority line and a late acknowledge check that there is no preemption and that the release waits for the acknowledge line to rise.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // not contending
    ST_ASK  = 3'd1,  // request and priority line pulled, awaiting grant
    ST_WON  = 3'd2,  // winner latched, awaiting end of current transfer
    ST_LOST = 3'd3,  // lost, holding lines until acknowledge appears
    ST_OWN  = 3'd4   // owns the bus
  } arb_state_e;
endpackage

// File: rtl/arb_prio_net.sv
// Priority network: this card wins when its own line is pulled low and
// no line of higher number is pulled low.
module arb_prio_net #(
  parameter int NUM_LINES = 7,
  parameter int MY_LEVEL  = 4
) (
  input  logic [NUM_LINES-1:0] dp_n_i,
  output logic                 mine_o
);
  localparam int MY_IDX = MY_LEVEL - 1;

  logic [NUM_LINES-1:0] above_mask;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_mask
    if (g > MY_IDX) begin : g_hi
      assign above_mask[g] = 1'b1;
    end else begin : g_lo
      assign above_mask[g] = 1'b0;
    end
  end

  logic higher_busy;
  assign higher_busy = |(~dp_n_i & above_mask);
  assign mine_o      = ~dp_n_i[MY_IDX] & ~higher_busy;
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic mine_i,
  input  logic br_n_i,
  input  logic bg_n_i,
  input  logic bgack_n_i,
  input  logic as_n_i,
  input  logic dtack_n_i,
  output logic br_n_o,
  output logic dp_n_o,
  output logic bgack_n_o,
  output logic drv_en_o,
  output logic proceed_o
);
  arb_state_e state_q, state_d;
  logic       state_en;
  logic       bus_quiet, xfer_done, requesting, owning;

  assign bus_quiet = br_n_i & bg_n_i & bgack_n_i;
  assign xfer_done = as_n_i & dtack_n_i;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i && bus_quiet) state_d = ST_ASK;
      ST_ASK: begin
        if (!bgack_n_i)   state_d = ST_IDLE;
        else if (!bg_n_i) state_d = mine_i ? ST_WON : ST_LOST;
      end
      ST_WON: begin
        if (!bgack_n_i)     state_d = ST_IDLE;
        else if (xfer_done) state_d = ST_OWN;
      end
      ST_LOST: if (!bgack_n_i) state_d = ST_IDLE;
      ST_OWN:  if (!req_i && dtack_n_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_en = (state_d != state_q);

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_IDLE;
    else if (state_en) state_q <= state_d;
  end

  // Moore output decode
  assign requesting = (state_q == ST_ASK) || (state_q == ST_WON) ||
                      (state_q == ST_LOST);
  assign owning     = (state_q == ST_OWN);

  assign br_n_o    = ~requesting;
  assign dp_n_o    = ~requesting;
  assign bgack_n_o = ~owning;
  assign drv_en_o  = owning;
  assign proceed_o = owning;
endmodule

// File: rtl/arb_unit.sv
module arb_unit #(
  parameter int NUM_LINES = 7,
  parameter int MY_LEVEL  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_i,
  output logic                 proceed_o,
  input  logic                 br_n_i,
  output logic                 br_n_o,
  input  logic                 bg_n_i,
  input  logic                 bgack_n_i,
  output logic                 bgack_n_o,
  input  logic                 as_n_i,
  input  logic                 dtack_n_i,
  input  logic [NUM_LINES-1:0] dp_n_i,
  output logic                 dp_n_o,
  output logic                 drv_en_o
);
  logic mine;

  arb_prio_net #(.NUM_LINES(NUM_LINES), .MY_LEVEL(MY_LEVEL)) i_prio (
    .dp_n_i (dp_n_i),
    .mine_o (mine)
  );

  arb_fsm i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .mine_i    (mine),
    .br_n_i    (br_n_i),
    .bg_n_i    (bg_n_i),
    .bgack_n_i (bgack_n_i),
    .as_n_i    (as_n_i),
    .dtack_n_i (dtack_n_i),
    .br_n_o    (br_n_o),
    .dp_n_o    (dp_n_o),
    .bgack_n_o (bgack_n_o),
    .drv_en_o  (drv_en_o),
    .proceed_o (proceed_o)
  );
endmodule

// File: rtl/arb_unit_chk.sv
module arb_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic req_i,
  input logic proceed_o,
  input logic br_n_i,
  input logic br_n_o,
  input logic bg_n_i,
  input logic bgack_n_i,
  input logic bgack_n_o,
  input logic as_n_i,
  input logic dtack_n_i,
  input logic dp_n_o,
  input logic drv_en_o
);
  assert_lines_paired_R2: assert property (@(posedge clk) disable iff (!rst_n)
    br_n_o == dp_n_o);

  assert_start_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(br_n_o) |-> $past(br_n_i && bg_n_i && bgack_n_i));

  assert_take_after_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bgack_n_o) |-> $past(as_n_i && dtack_n_i));

  assert_drop_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_n_o && bgack_n_o && !bgack_n_i) |=> br_n_o);

  assert_no_preempt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bgack_n_o && !(dtack_n_i && !req_i)) |=> !bgack_n_o);

  assert_release_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bgack_n_o) |-> $past(dtack_n_i && !req_i));

  assert_proceed_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (proceed_o == !bgack_n_o) && (drv_en_o == !bgack_n_o));

  assert_owner_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bgack_n_o |-> (br_n_o && dp_n_o));
endmodule

bind arb_unit arb_unit_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_i     (req_i),
  .proceed_o (proceed_o),
  .br_n_i    (br_n_i),
  .br_n_o    (br_n_o),
  .bg_n_i    (bg_n_i),
  .bgack_n_i (bgack_n_i),
  .bgack_n_o (bgack_n_o),
  .as_n_i    (as_n_i),
  .dtack_n_i (dtack_n_i),
  .dp_n_o    (dp_n_o),
  .drv_en_o  (drv_en_o)
);

// File: tb/test_arb_unit.sv
`timescale 1ns/1ps
module test_arb_unit;
  localparam int NL  = 7;
  localparam int LVL = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic req;
  logic other_br_n, bg_n, other_bgack_n, as_n, dtack_n;
  logic [NL-1:0] other_dp_n;
  logic proceed, br_n_o, bgack_n_o, dp_n_o, drv_en;
  logic br_bus, bgack_bus;
  logic [NL-1:0] dp_bus, dut_dp;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    dut_dp = '1;
    dut_dp[LVL-1] = dp_n_o;
  end
  assign dp_bus    = other_dp_n & dut_dp;
  assign br_bus    = other_br_n & br_n_o;
  assign bgack_bus = other_bgack_n & bgack_n_o;

  arb_unit #(.NUM_LINES(NL), .MY_LEVEL(LVL)) i_arb_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req),
    .proceed_o (proceed),
    .br_n_i    (br_bus),
    .br_n_o    (br_n_o),
    .bg_n_i    (bg_n),
    .bgack_n_i (bgack_bus),
    .bgack_n_o (bgack_n_o),
    .as_n_i    (as_n),
    .dtack_n_i (dtack_n),
    .dp_n_i    (dp_bus),
    .dp_n_o    (dp_n_o),
    .drv_en_o  (drv_en)
  );

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one rising edge, then settle; inputs change and outputs are sampled here
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // {br, dp, bgack, drv_en, proceed}
  function automatic logic [7:0] outs();
    return {3'b0, br_n_o, dp_n_o, bgack_n_o, drv_en, proceed};
  endfunction

  task automatic bus_idle();
    other_br_n = 1; bg_n = 1; other_bgack_n = 1; as_n = 1; dtack_n = 1;
    other_dp_n = '1;
  endtask

  task automatic t_reset();
    rst_n = 0; req = 1; bus_idle();
    repeat (3) step();
    chk("R1 outputs in reset", outs(), 8'b0001_1100);
    req = 0;
    rst_n = 1;
    step();
    chk("R1 idle after reset", outs(), 8'b0001_1100);
  endtask

  task automatic t_blocked();
    req = 1; other_br_n = 0;
    repeat (3) step();
    chk("R3 busy request line blocks", {7'b0, br_n_o}, 8'd1);
    other_br_n = 1; bg_n = 0;
    repeat (2) step();
    chk("R3 low grant blocks", {7'b0, br_n_o}, 8'd1);
    bg_n = 1; other_bgack_n = 0;
    repeat (2) step();
    chk("R3 foreign ack blocks", {7'b0, br_n_o}, 8'd1);
    other_bgack_n = 1;
    step();
    chk("R2 request and priority low together", {6'b0, br_n_o, dp_n_o}, 8'd0);
  endtask

  task automatic t_win();
    // enters here already requesting
    as_n = 0; dtack_n = 1; bg_n = 0;
    step();
    chk("R4 alone: still requesting at grant", {7'b0, br_n_o}, 8'd0);
    repeat (3) step();
    chk("R5 waits while strobe low", {7'b0, bgack_n_o}, 8'd1);
    as_n = 1;
    step();
    chk("R5 takes bus after transfer ends", {7'b0, bgack_n_o}, 8'd0);
    chk("R9 proceed and driver enable", {6'b0, drv_en, proceed}, 8'd3);
    chk("R10 owner releases request lines", {6'b0, br_n_o, dp_n_o}, 8'd3);
    bg_n = 1; other_dp_n[NL-1] = 0; other_br_n = 0;
    repeat (4) step();
    chk("R7 higher line does not preempt", {7'b0, bgack_n_o}, 8'd0);
    req = 0; dtack_n = 0;
    repeat (2) step();
    chk("R8 release held while ack low", {7'b0, bgack_n_o}, 8'd0);
    dtack_n = 1;
    step();
    chk("R8 released", outs(), 8'b0001_1100);
    chk("R9 proceed low after release", {7'b0, proceed}, 8'd0);
    bus_idle();
    step();
  endtask

  task automatic t_lose();
    req = 1;
    step();
    chk("R2 re-request", {7'b0, br_n_o}, 8'd0);
    other_dp_n[5] = 0; other_br_n = 0; bg_n = 0;
    step();
    step();
    chk("R4 loser keeps lines", {6'b0, br_n_o, dp_n_o}, 8'd0);
    chk("R4 loser does not take bus", {7'b0, bgack_n_o}, 8'd1);
    other_bgack_n = 0;
    step();
    chk("R6 loser drops on foreign ack", {6'b0, br_n_o, dp_n_o}, 8'd3);
    bg_n = 1; other_dp_n = '1; other_br_n = 1;
    repeat (2) step();
    chk("R3 no restart while ack held", {7'b0, br_n_o}, 8'd1);
    other_bgack_n = 1;
    step();
    chk("R6 asks again on quiet bus", {6'b0, br_n_o, dp_n_o}, 8'd0);
    other_dp_n[0] = 0; bg_n = 0;
    step();
    step();
    chk("R4 lower line does not block win", {7'b0, bgack_n_o}, 8'd0);
    req = 0; bus_idle();
    step();
    chk("R8 release after win", outs(), 8'b0001_1100);
  endtask

  initial begin
    t_reset();
    t_blocked();
    t_win();
    t_lose();
    done = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
    end
  end
endmodule